// File: doc/BRIEF.md
# Two-Wire Bus Event Flag Controller

This block holds the event flags of a two-wire serial bus peripheral that can act as master or slave. The bus engine reports hardware events as one-cycle pulses: a start condition was sent, the own slave address was matched, the master address phase finished, a received or transmitted byte completed, an acknowledge was missing, or a stop condition was seen. The processor side reports its register accesses as one-cycle strobes: a read of the first status register, a read of the second status register, a read or write of the data register, and a write of the control register.

Most flags do not clear on a single access. They need a two-step sequence: a read of the first status register that arms the controller, followed by a specific data or control access. One arm bit records the first step. The next data or control access consumes it, and a read of the second status register cancels it. A summary output is raised while any flag is pending, and an interrupt line follows that summary one cycle later when the interrupt enable input is high.

Top module: `i2c_evflag_ctl`

## Requirements
- R1: After reset every flag output, `pend` and `irq` are 0, no sequence is armed, and the held stop bit and the stop-suppress state are cleared.
- R2: `pend` is 1 in the same cycle that any flag is pending, including the internal address-phase flag. `irq` equals the value of `pend` AND `irq_en` from the previous cycle.
- R3: `ev_addr_match` sets `f_addr_hit`. A `stat_a_rd` strobe on its own clears it.
- R4: `ev_byte_rx` sets `f_xfer` of receive kind. It clears only on a `data_rd` that comes while the controller is armed. A `data_wr` or `ctrl_wr` does not clear it.
- R5: `ev_byte_tx` sets `f_xfer` of transmit kind. It clears only on a `data_wr` that comes while the controller is armed.
- R6: `ev_start` sets `f_start`. It clears only on a `data_wr` that comes while the controller is armed.
- R7: `ev_addr_done` sets an internal address-phase flag that is seen only through `pend`. It clears only on a `ctrl_wr` that comes while the controller is armed.
- R8: `ev_nack` sets `f_nack` and sets `f_xfer` of no-acknowledge kind. A `stat_a_rd` clears `f_nack`. This `f_xfer` clears only on a `data_wr` with `wr_data` all ones (FFh), or on a line release. A line release is a `ctrl_wr` with `ctrl_stop`=0 while the stop bit last written was 1. A `data_wr` of any other value leaves it set.
- R9: A line release makes the controller ignore the next `ev_stop` pulse, so that pulse does not set `f_stop`. The `ev_stop` pulse after it sets `f_stop` as usual.
- R10: `ev_stop` sets `f_stop` unless it is suppressed. A `stat_b_rd` clears `f_stop`.
- R11: `stat_a_rd` arms the controller. The next `data_rd`, `data_wr` or `ctrl_wr` consumes the arm, and a `stat_b_rd` cancels it. A data or control access made while the controller is not armed clears no flag.
- R12: When a flag's set event and its clearing access arrive in the same cycle, the flag ends the cycle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Pulse: start condition generated |
| ev_addr_match | input | 1 | Pulse: own slave address matched |
| ev_addr_done | input | 1 | Pulse: master address phase finished |
| ev_byte_rx | input | 1 | Pulse: received byte finished |
| ev_byte_tx | input | 1 | Pulse: transmitted byte finished |
| ev_nack | input | 1 | Pulse: acknowledge missing |
| ev_stop | input | 1 | Pulse: stop condition seen |
| stat_a_rd | input | 1 | Strobe: first status register read |
| stat_b_rd | input | 1 | Strobe: second status register read |
| data_rd | input | 1 | Strobe: data register read |
| data_wr | input | 1 | Strobe: data register write |
| wr_data | input | DW | Data written along with `data_wr` |
| ctrl_wr | input | 1 | Strobe: control register write |
| ctrl_stop | input | 1 | Stop bit value written along with `ctrl_wr` |
| irq_en | input | 1 | Interrupt enable |
| f_start | output | 1 | Start-sent flag |
| f_addr_hit | output | 1 | Address-matched flag |
| f_xfer | output | 1 | Byte-transfer-finished flag |
| f_nack | output | 1 | Acknowledge-failure flag |
| f_stop | output | 1 | Stop-detected flag |
| pend | output | 1 | Any event pending |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume the processor makes at most one register access per cycle, and one of them checks that assumption on the access strobes. They also assume the bus engine pulses each event for exactly one cycle. The bench drives every event and every access as a single-cycle pulse followed by an idle cycle, and never combines two accesses in one cycle. It sweeps every two-step clear against every possible second access, with the arm present, absent, or cancelled. Events and accesses are combined in one cycle only to test the case where a set and a clear collide.

// File: rtl/i2c_evflag_ctl.sv
module i2c_evflag_ctl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  logic          ev_addr_match,
  input  logic          ev_addr_done,
  input  logic          ev_byte_rx,
  input  logic          ev_byte_tx,
  input  logic          ev_nack,
  input  logic          ev_stop,
  input  logic          stat_a_rd,
  input  logic          stat_b_rd,
  input  logic          data_rd,
  input  logic          data_wr,
  input  logic [DW-1:0] wr_data,
  input  logic          ctrl_wr,
  input  logic          ctrl_stop,
  input  logic          irq_en,
  output logic          f_start,
  output logic          f_addr_hit,
  output logic          f_xfer,
  output logic          f_nack,
  output logic          f_stop,
  output logic          pend,
  output logic          irq
);

  localparam logic [DW-1:0] RELEASE_BYTE = '1;

  typedef enum logic [1:0] {XK_RX, XK_TX, XK_NACK} xfer_kind_t;

  logic       arm_q, stop_held_q, supp_q, phase_q, irq_q;
  logic       start_q, hit_q, xfer_q, nack_q, stop_q;
  xfer_kind_t kind_q;

  wire any_access = stat_b_rd | data_rd | data_wr | ctrl_wr;
  wire release_w  = ctrl_wr & ~ctrl_stop & stop_held_q;
  wire clr_dr     = arm_q & data_rd;
  wire clr_dw     = arm_q & data_wr;
  wire clr_cw     = arm_q & ctrl_wr;
  wire xfer_ev    = ev_byte_rx | ev_byte_tx | ev_nack;

  logic xfer_clr;
  always_comb begin
    unique case (kind_q)
      XK_RX:   xfer_clr = clr_dr;
      XK_TX:   xfer_clr = clr_dw;
      XK_NACK: xfer_clr = (data_wr && wr_data == RELEASE_BYTE) || release_w;
      default: xfer_clr = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q       <= 1'b0;
      stop_held_q <= 1'b0;
      supp_q      <= 1'b0;
      phase_q     <= 1'b0;
      start_q     <= 1'b0;
      hit_q       <= 1'b0;
      xfer_q      <= 1'b0;
      kind_q      <= XK_RX;
      nack_q      <= 1'b0;
      stop_q      <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      if (stat_a_rd)       arm_q <= 1'b1;
      else if (any_access) arm_q <= 1'b0;

      if (ctrl_wr) stop_held_q <= ctrl_stop;

      if (release_w)    supp_q <= 1'b1;
      else if (ev_stop) supp_q <= 1'b0;

      if (ev_addr_match)  hit_q <= 1'b1;
      else if (stat_a_rd) hit_q <= 1'b0;

      if (ev_start)    start_q <= 1'b1;
      else if (clr_dw) start_q <= 1'b0;

      if (ev_addr_done) phase_q <= 1'b1;
      else if (clr_cw)  phase_q <= 1'b0;

      if (ev_nack)        nack_q <= 1'b1;
      else if (stat_a_rd) nack_q <= 1'b0;

      if (xfer_ev) begin
        xfer_q <= 1'b1;
        kind_q <= ev_nack ? XK_NACK : (ev_byte_tx ? XK_TX : XK_RX);
      end else if (xfer_clr) begin
        xfer_q <= 1'b0;
      end

      if (ev_stop && !supp_q) stop_q <= 1'b1;
      else if (stat_b_rd)     stop_q <= 1'b0;

      irq_q <= pend & irq_en;
    end
  end

  assign f_start    = start_q;
  assign f_addr_hit = hit_q;
  assign f_xfer     = xfer_q;
  assign f_nack     = nack_q;
  assign f_stop     = stop_q;
  assign pend       = start_q | hit_q | xfer_q | nack_q | stop_q | phase_q;
  assign irq        = irq_q;

  // input assumption: one register access per cycle
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat_a_rd, stat_b_rd, data_rd, data_wr, ctrl_wr}));

  // R2
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == ($past(pend) && $past(irq_en)));

  // R3
  hit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_a_rd && !ev_addr_match |=> !f_addr_hit);

  // R10
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_b_rd && !ev_stop |=> !f_stop);

  // R12
  hit_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_match |=> f_addr_hit);

  // R11
  unarmed_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_q && data_rd && f_xfer |=> f_xfer);

  // R9
  stop_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supp_q && ev_stop && !f_stop |=> !f_stop);

  // R6
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_start && !data_wr |=> f_start);

endmodule

// File: tb/i2c_evflag_ctl_test.sv
module i2c_evflag_ctl_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [11:0] E_START = 12'h001, E_HIT = 12'h002, E_RX = 12'h004,
                          E_TX = 12'h008, E_NACK = 12'h010, E_STOP = 12'h020,
                          E_PHASE = 12'h040, A_STA = 12'h080, A_STB = 12'h100,
                          A_DRD = 12'h200, A_DWR = 12'h400, A_CWR = 12'h800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] drv = '0;
  logic [7:0] wr_data = '0;
  logic ctrl_stop = 1'b0, irq_en = 1'b0;
  logic f_start, f_addr_hit, f_xfer, f_nack, f_stop, pend, irq;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_evflag_ctl #(.DW(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .ev_start(drv[0]), .ev_addr_match(drv[1]), .ev_addr_done(drv[6]),
    .ev_byte_rx(drv[2]), .ev_byte_tx(drv[3]), .ev_nack(drv[4]), .ev_stop(drv[5]),
    .stat_a_rd(drv[7]), .stat_b_rd(drv[8]), .data_rd(drv[9]), .data_wr(drv[10]),
    .wr_data(wr_data), .ctrl_wr(drv[11]), .ctrl_stop(ctrl_stop), .irq_en(irq_en),
    .f_start(f_start), .f_addr_hit(f_addr_hit), .f_xfer(f_xfer), .f_nack(f_nack),
    .f_stop(f_stop), .pend(pend), .irq(irq));

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [11:0] v);
    @(negedge clk); drv = v;
    @(negedge clk); drv = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; drv = '0; wr_data = '0; ctrl_stop = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] acc [5] = '{A_STA, A_STB, A_DRD, A_DWR, A_CWR};
    logic [11:0] evk [4] = '{E_RX, E_TX, E_START, E_PHASE};
    int          need[4] = '{2, 3, 3, 4};
    string       tagk[4] = '{"R4", "R5", "R6", "R7"};

    do_reset();
    // R1 reset state
    chk("R1 f_start", f_start, 1'b0);  chk("R1 f_addr_hit", f_addr_hit, 1'b0);
    chk("R1 f_xfer", f_xfer, 1'b0);    chk("R1 f_nack", f_nack, 1'b0);
    chk("R1 f_stop", f_stop, 1'b0);    chk("R1 pend", pend, 1'b0);
    chk("R1 irq", irq, 1'b0);

    // R4..R7 with R11: sweep first step (none/armed/cancelled) x second access
    for (int k = 0; k < 4; k++)
      for (int f = 0; f < 3; f++)
        for (int s = 0; s < 5; s++) begin
          logic exp_clr, obs;
          do_reset();
          cyc(evk[k]);
          if (f >= 1) cyc(A_STA);
          if (f == 2) cyc(A_STB);
          cyc(acc[s]);
          exp_clr = (f == 1) && (s == need[k]);
          obs = (k < 2) ? f_xfer : (k == 2) ? f_start : pend;
          chk(f == 2 ? "R11 cancelled arm" : tagk[k], obs, !exp_clr);
          chk("R2 pend", pend, !exp_clr);
        end

    // R11: arm consumed by one access, second access unarmed does nothing
    do_reset();
    cyc(E_START); cyc(A_STA); cyc(A_DRD); cyc(A_DWR);
    chk("R11 consumed arm", f_start, 1'b1);

    // R2: irq timing for both enables
    for (int en = 0; en < 2; en++) begin
      do_reset();
      irq_en = en[0];
      cyc(E_HIT);
      chk("R2 pend same cycle", pend, 1'b1);
      chk("R2 irq not yet", irq, 1'b0);
      @(negedge clk);
      chk("R2 irq registered", irq, en[0]);
      cyc(A_STA);
      chk("R3 hit cleared", f_addr_hit, 1'b0);
      @(negedge clk);
      chk("R2 irq drops", irq, 1'b0);
    end
    irq_en = 1'b0;

    // R8: no-acknowledge, clear via FFh write
    do_reset();
    cyc(E_NACK);
    chk("R8 nack set", f_nack, 1'b1); chk("R8 xfer set", f_xfer, 1'b1);
    cyc(A_STA);
    chk("R8 nack cleared", f_nack, 1'b0); chk("R8 xfer held", f_xfer, 1'b1);
    wr_data = 8'h55; cyc(A_DWR);
    chk("R8 non-FF write", f_xfer, 1'b1);
    wr_data = 8'hFF; cyc(A_DWR);
    chk("R8 FF write clears", f_xfer, 1'b0);

    // R8/R9/R10: release clears and suppresses one stop
    do_reset();
    cyc(E_NACK); cyc(A_STA);
    ctrl_stop = 1'b1; cyc(A_CWR);
    chk("R8 stop set alone", f_xfer, 1'b1);
    ctrl_stop = 1'b0; cyc(A_CWR);
    chk("R8 release clears", f_xfer, 1'b0);
    cyc(E_STOP);
    chk("R9 stop suppressed", f_stop, 1'b0);
    cyc(E_STOP);
    chk("R10 next stop sets", f_stop, 1'b1);
    cyc(A_STA);
    chk("R10 status-a no clear", f_stop, 1'b1);
    cyc(A_STB);
    chk("R10 status-b clears", f_stop, 1'b0);

    // R12: set wins against clear in the same cycle
    do_reset();
    cyc(E_HIT); cyc(A_STA | E_HIT);
    chk("R12 hit set wins", f_addr_hit, 1'b1);
    cyc(E_START); cyc(A_STA); cyc(A_DWR | E_START);
    chk("R12 start set wins", f_start, 1'b1);
    cyc(E_STOP); cyc(A_STB | E_STOP);
    chk("R12 stop set wins", f_stop, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule